// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block divides a fast input clock by a programmable ratio and marks the end of every division period. It builds the ratio from a 16/17 dual-modulus stage driven by two nested down-counters. The upper field of the ratio word sets the number of prescaler cycles in each period. The lower field sets how many of those cycles use the longer modulus. The total count of input ticks per period is therefore 16·M + A. An optional divide-by-two stage ahead of the dual-modulus stage gates the ticks. It doubles both the total ratio and the smallest step.

Ratio and divide-by-two settings come from a control register, and the block takes them in only at the clock edge that ends a period. The same edge starts the next period. A control interface can watch the boundary strobe to see when its last write was taken up. The feedback pulse goes to a phase comparator. The fast input clock is treated as an ordinary clock, so the analog front end is not part of this block.

Top module: `dmd_divider`

## Requirements
- R1: While reset is held, `pulse_o` is 0 and `boundary_o` is 1. The first rising clock edge after release samples `ratio_i` and `half_en_i`, and the first `pulse_o` appears N+1 clocks after that edge, where N is the effective ratio.
- R2: With `half_en_i` = 0 taken up, consecutive `pulse_o` assertions lie exactly 16·M + A clocks apart. M is `ratio_i[16:4]` and A is `ratio_i[3:0]`.
- R3: With `half_en_i` = 1 taken up, consecutive `pulse_o` assertions lie exactly 2·(16·M + A) clocks apart. While the divide-by-two stage is active, the internal tick is never high in two adjacent cycles except across a period boundary.
- R4: A `ratio_i` value below 240 is used as 240, giving a period of 240 clocks, or 480 with divide-by-two.
- R5: `ratio_i` and `half_en_i` are sampled only at the clock edge that ends a cycle in which `boundary_o` is 1. Changes at any other time, including changes that are reverted before that edge, do not affect the period in progress.
- R6: `pulse_o` is high for exactly one clock, and it is high only in the clock directly after a clock in which `boundary_o` was high.
- R7: `boundary_o` is high for one clock per period, and no two boundaries are closer than 240 clocks.
- R8: The extreme ratios 240 and 131071 are divided exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_i | input | 17 | Division word: bits 16:4 prescaler cycle count M, bits 3:0 long-modulus count A |
| half_en_i | input | 1 | 1 inserts the divide-by-two stage |
| pulse_o | output | 1 | One-clock feedback pulse, once per period |
| boundary_o | output | 1 | High in the last clock of a period; the settings are sampled at its closing edge |

## Verification
A corrupted M or A down-counter, or a stuck modulus select, changes the pulse spacing in the period where it happens. The error is visible at the very next `pulse_o`, as a count that is off by a multiple of 16 or by a few clocks. A wrong divide-by-two phase either doubles the spacing or fails to double it in the first period after the setting is taken up. Settings that are sampled at the wrong moment show up one period early, in the interval that should still carry the old ratio. The tests therefore measure that specific interval after every change.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    localparam int unsigned DEF_A_W = 4;
    localparam int unsigned DEF_M_W = 13;

    // smallest ratio for which every long-modulus count fits under the cycle count
    function automatic int unsigned min_ratio(input int unsigned a_w);
        return (1 << a_w) * ((1 << a_w) - 1);
    endfunction

endpackage

// File: rtl/dmd_half_stage.sv
module dmd_half_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic half_i,
    output logic tick_o
);

    typedef struct packed {
        logic ph;
    } half_t;

    half_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ph = half_i & ~st_q.ph;
        tick_o  = ~half_i | st_q.ph;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
    parameter int unsigned A_W = dmd_pkg::DEF_A_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic mod17_i,
    input  logic restart_i,
    output logic wrap_o
);

    localparam int unsigned PRE_W    = A_W + 1;
    localparam int unsigned PRE_BASE = 1 << A_W;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PRE_W-1:0] last_val;

    always_comb begin
        st_d     = st_q;
        last_val = mod17_i ? PRE_W'(PRE_BASE) : PRE_W'(PRE_BASE - 1);
        wrap_o   = tick_i & (st_q.cnt == last_val);
        if (restart_i || wrap_o) st_d.cnt = '0;
        else if (tick_i)         st_d.cnt = st_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dmd_swallow_ctl.sv
module dmd_swallow_ctl #(
    parameter int unsigned A_W = dmd_pkg::DEF_A_W,
    parameter int unsigned M_W = dmd_pkg::DEF_M_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wrap_i,
    input  logic [A_W+M_W-1:0]   ratio_i,
    input  logic                 half_en_i,
    output logic                 mod17_o,
    output logic                 half_o,
    output logic                 term_o,
    output logic                 pulse_o
);

    localparam int unsigned RATIO_W   = A_W + M_W;
    localparam int unsigned MIN_RATIO = dmd_pkg::min_ratio(A_W);
    localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(MIN_RATIO);

    typedef struct packed {
        logic           start;
        logic [M_W-1:0] m_left;
        logic [A_W-1:0] a_left;
        logic           half;
        logic           pulse;
    } swl_t;

    swl_t st_d, st_q;
    logic [RATIO_W-1:0] eff;
    logic               term;

    always_comb begin
        st_d       = st_q;
        eff        = (ratio_i < MIN_R) ? MIN_R : ratio_i;
        term       = st_q.start | (wrap_i & (st_q.m_left == M_W'(1)));
        st_d.start = 1'b0;
        st_d.pulse = term & ~st_q.start;
        if (term) begin
            st_d.m_left = eff[RATIO_W-1:A_W];
            st_d.a_left = eff[A_W-1:0];
            st_d.half   = half_en_i;
        end else if (wrap_i) begin
            st_d.m_left = st_q.m_left - M_W'(1);
            if (st_q.a_left != '0) st_d.a_left = st_q.a_left - A_W'(1);
        end
        mod17_o = (st_q.a_left != '0);
        half_o  = st_q.half;
        term_o  = term;
        pulse_o = st_q.pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.start <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dmd_divider.sv
module dmd_divider #(
    parameter int unsigned A_W = dmd_pkg::DEF_A_W,
    parameter int unsigned M_W = dmd_pkg::DEF_M_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [A_W+M_W-1:0] ratio_i,
    input  logic               half_en_i,
    output logic               pulse_o,
    output logic               boundary_o
);

    localparam int unsigned MIN_RATIO = dmd_pkg::min_ratio(A_W);

    logic tick_w;
    logic wrap_w;
    logic mod17_w;
    logic half_w;
    logic term_w;

    dmd_half_stage u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (half_w),
        .tick_o (tick_w)
    );

    dmd_prescaler #(.A_W(A_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_w),
        .mod17_i   (mod17_w),
        .restart_i (term_w),
        .wrap_o    (wrap_w)
    );

    dmd_swallow_ctl #(.A_W(A_W), .M_W(M_W)) u_swl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap_w),
        .ratio_i   (ratio_i),
        .half_en_i (half_en_i),
        .mod17_o   (mod17_w),
        .half_o    (half_w),
        .term_o    (term_w),
        .pulse_o   (pulse_o)
    );

    assign boundary_o = term_w;

endmodule

// File: rtl/dmd_divider_chk.sv
module dmd_divider_chk #(
    parameter int unsigned MIN_RATIO = 240
) (
    input logic clk,
    input logic rst_n,
    input logic pulse,
    input logic boundary,
    input logic tick,
    input logic half_act
);

    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (boundary) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 32'd1;
        end
    end

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R6
    pulse_after_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(boundary));

    // R7
    bnd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> !boundary);

    // R7
    bnd_min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && seen_q) |-> (gap_q >= 32'(MIN_RATIO - 1)));

    // R3
    half_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_act && tick && !boundary) |=> !tick);

endmodule

bind dmd_divider dmd_divider_chk #(.MIN_RATIO(MIN_RATIO)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse    (pulse_o),
    .boundary (boundary_o),
    .tick     (tick_w),
    .half_act (half_w)
);

// File: tb/sim_dmd_divider.sv
module sim_dmd_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] ratio = 17'd240;
    logic        half = 1'b0;
    logic        pulse_o;
    logic        boundary_o;

    int checks = 0;
    int fails  = 0;
    bit prev_bnd = 1'b0;

    always #10 clk = ~clk;

    dmd_divider u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_i    (ratio),
        .half_en_i  (half),
        .pulse_o    (pulse_o),
        .boundary_o (boundary_o)
    );

    function automatic int exp_period(input int r, input bit h);
        int e;
        e = (r < 240) ? 240 : r;
        return h ? 2 * e : e;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns posedges until pulse_o seen
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            prev_bnd = boundary_o;
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!pulse_o && n < 300000);
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        ratio = 17'd240;
        half  = 1'b0;
        repeat (3) @(negedge clk);
        chk(pulse_o == 1'b0, "R1 pulse in reset", int'(pulse_o), 0);
        chk(boundary_o == 1'b1, "R1 boundary in reset", int'(boundary_o), 1);
        rst_n = 1'b1;
        wait_pulse(n);
        chk(n == 241, "R1 first pulse", n, 241);
    endtask

    task automatic t_ratio(input int r, input bit h, input string req);
        int n;
        ratio = 17'(r);
        half  = h;
        wait_pulse(n);
        wait_pulse(n);
        chk(n == exp_period(r, h), req, n, exp_period(r, h));
    endtask

    task automatic t_random();
        for (int i = 0; i < 6; i++) begin
            int r;
            r = int'($urandom_range(240, 1200));
            t_ratio(r, bit'(i % 2), (i % 2) ? "R3 random" : "R2 random");
        end
    endtask

    task automatic t_midchange();
        int n;
        ratio = 17'd500;
        half  = 1'b0;
        wait_pulse(n);
        wait_pulse(n);
        ratio = 17'd300;
        half  = 1'b1;
        repeat (100) @(negedge clk);
        ratio = 17'd500;
        half  = 1'b0;
        wait_pulse(n);
        chk(n + 100 == 500, "R5 reverted change", n + 100, 500);
        ratio = 17'd700;
        wait_pulse(n);
        chk(n == 500, "R5 old ratio kept", n, 500);
        wait_pulse(n);
        chk(n == 700, "R5 new ratio applied", n, 700);
    endtask

    task automatic t_handshake();
        int n;
        ratio = 17'd300;
        half  = 1'b0;
        wait_pulse(n);
        chk(prev_bnd == 1'b1, "R6 boundary before pulse", int'(prev_bnd), 1);
        @(posedge clk);
        @(negedge clk);
        chk(pulse_o == 1'b0, "R6 pulse width", int'(pulse_o), 0);
        chk(boundary_o == 1'b0, "R7 boundary width", int'(boundary_o), 0);
        wait_pulse(n);
        chk(n == 299, "R6 spacing after step", n, 299);
    endtask

    task automatic t_max();
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        ratio = 17'd131071;
        half  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wait_pulse(n);
        chk(n == 131072, "R8 max ratio", n, 131072);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_ratio(240, 1'b0, "R8 min ratio");
        t_ratio(255, 1'b0, "R2 A=15");
        t_ratio(256, 1'b0, "R2 A=0");
        t_ratio(1023, 1'b1, "R3 halved");
        t_ratio(0, 1'b0, "R4 clamp zero");
        t_ratio(239, 1'b1, "R4 clamp halved");
        t_random();
        t_midchange();
        t_handshake();
        t_max();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule